// File: doc/BRIEF.md
# Addend-Trimmed Precision Time Counter

This block keeps a free-running 64-bit time-of-day count for precision timing. Its rate is set by a 32-bit addend instead of a fixed increment. On every clock the addend is added into a 32-bit phase accumulator, and each carry out of that sum advances the time count by one tick. With the addend at 0xA0000000, one tick stands for 32 ns, so the time in nanoseconds is the count shifted left by five. A servo outside the block trims the frequency with `addend = base ± base*ppb/10^9`. Corrections as large as ±50,000,000 ppb (±5 %, which gives 0xA8000000 and 0x98000000) fit in the register.

Software reaches the block through a small 32-bit register bus. Reads are combinational, and reads and writes each take a single cycle. The 64-bit time is accessed as two words, always low word first. A low-word read latches the high word into a shadow register, so the pair stays coherent. A low-word write only stages the value, and the high-word write then loads both words at once. The wrap point of the low word is programmable, but only behind an enable register. A control bit holds the timing logic in soft reset for as long as it is set.

Register word addresses: 0 control (bit 0 soft reset), 1 addend, 2 time low, 3 time high, 4 limit write enable (bit 0), 5 low-word limit.

Top module: `ptp_tod_counter`

## Requirements
- R1: After `rst_n` is asserted, the addend reads 0xA0000000, the control word and the limit enable read 0, the limit reads 0xFFFFFFFF, and the time and the phase accumulator are zero.
- R2: Each clock adds the addend into a 32-bit phase accumulator, and the carry out advances the time by one. Starting from a cleared accumulator, the time after m clocks has advanced by floor(m*addend/2^32).
- R3: A write to address 2 only stages a low word and leaves the running time unchanged. A write to address 3 loads {written high, staged low} on that clock edge and clears the phase accumulator.
- R4: A read of address 2 returns the live low word and, on that clock edge, copies the live high word into a shadow. A read of address 3 returns the shadow, so a pair read low-then-high stays coherent even across a low-word wrap.
- R5: When a tick occurs while the low word is greater than or equal to the limit, the low word becomes 0 and the high word increments. With the limit at 0xFFFFFFFF this is a plain 64-bit carry with no gap.
- R6: A write to address 5 changes the limit only while bit 0 of address 4 holds 1. Otherwise the write is ignored.
- R7: While control bit 0 is 1, the time and the accumulator are held at zero and time loads are ignored. The addend and the limit keep their values. After the bit is cleared, counting restarts from zero with a cleared accumulator.
- R8: The addend is a full 32-bit read/write register and is used from the next clock. The trimmed values 0xA8000000 and 0x98000000 produce the rates R2 predicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (latches the shadow on a low-word read) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| time_now | output | 64 | Live time count |
| tick | output | 1 | High in a cycle whose clock edge advances the time |

## Verification
A corrupted phase accumulator does not show at once. It shows as a time that is one tick early or late, only after enough clocks for the fractional error to reach a carry. For that reason the bench compares the time against floor(m*addend/2^32) over windows of up to a thousand cycles, for several addends. A broken shadow shows at the very next high-word read taken across a low-word wrap. A broken limit guard or wrap comparison shows within one tick of the low word reaching the limit, as a low word that never returns to zero or a high word that does not step.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_ADDEND  = 3'd1,
        REG_TIME_LO = 3'd2,
        REG_TIME_HI = 3'd3,
        REG_LIM_EN  = 3'd4,
        REG_LIMIT   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/tod_phase_acc.sv
`timescale 1ns/1ps
module tod_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [ACC_W-1:0] addend,
    output logic             carry
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        sum    = {1'b0, st_q.acc} + {1'b0, addend};
        st_d   = st_q;
        carry  = 1'b0;
        if (clear) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = sum[ACC_W-1:0];
            carry    = sum[ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3 / R7: a clear leaves the accumulator empty
    p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.acc == '0));
endmodule

// File: rtl/tod_time_count.sv
`timescale 1ns/1ps
module tod_time_count #(
    parameter int WORD_W = 32,
    localparam int TIME_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    input  logic              tick,
    input  logic [WORD_W-1:0] limit,
    output logic [TIME_W-1:0] time_q
);
    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } time_state_t;

    time_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d = '0;
        end else if (load) begin
            st_d.hi = load_val[TIME_W-1:WORD_W];
            st_d.lo = load_val[WORD_W-1:0];
        end else if (tick) begin
            if (st_q.lo >= limit) begin
                st_d.lo = '0;
                st_d.hi = st_q.hi + 1'b1;
            end else begin
                st_d.lo = st_q.lo + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_q = {st_q.hi, st_q.lo};

    // R2: without a tick, load or hold the time does not move
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !load && !tick) |=> $stable(time_q));

    // R5: a tick at or above the limit wraps low and steps high
    p_wrap_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !load && tick && (st_q.lo >= limit))
        |=> ((st_q.lo == '0) && (st_q.hi == $past(st_q.hi) + 1'b1)));

    // R7: soft reset forces zero time
    p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (time_q == '0));
endmodule

// File: rtl/tod_regs.sv
`timescale 1ns/1ps
module tod_regs
    import tod_pkg::*;
#(
    parameter int          WORD_W       = 32,
    parameter logic [31:0] ADDEND_RESET = 32'hA000_0000,
    parameter logic [31:0] LIMIT_RESET  = 32'hFFFF_FFFF,
    localparam int         TIME_W       = 2 * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [TIME_W-1:0]     time_now,
    output logic [WORD_W-1:0]     addend,
    output logic [WORD_W-1:0]     limit,
    output logic                  soft_rst,
    output logic                  load,
    output logic [TIME_W-1:0]     load_val
);
    typedef struct packed {
        logic              ctrl_rst;
        logic              lim_en;
        logic [WORD_W-1:0] addend;
        logic [WORD_W-1:0] limit;
        logic [WORD_W-1:0] stage_lo;
        logic [WORD_W-1:0] shadow_hi;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        load_val = {bus_wdata, st_q.stage_lo};
        if (bus_wr) begin
            unique case (bus_addr)
                REG_CTRL:    st_d.ctrl_rst = bus_wdata[0];
                REG_ADDEND:  st_d.addend   = bus_wdata;
                REG_TIME_LO: st_d.stage_lo = bus_wdata;
                REG_TIME_HI: load          = !st_q.ctrl_rst;
                REG_LIM_EN:  st_d.lim_en   = bus_wdata[0];
                REG_LIMIT:   if (st_q.lim_en) st_d.limit = bus_wdata;
                default: ;
            endcase
        end
        if (bus_rd && (bus_addr == REG_TIME_LO))
            st_d.shadow_hi = time_now[TIME_W-1:WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.addend    <= ADDEND_RESET[WORD_W-1:0];
            st_q.limit     <= LIMIT_RESET[WORD_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL:    bus_rdata[0] = st_q.ctrl_rst;
            REG_ADDEND:  bus_rdata    = st_q.addend;
            REG_TIME_LO: bus_rdata    = time_now[WORD_W-1:0];
            REG_TIME_HI: bus_rdata    = st_q.shadow_hi;
            REG_LIM_EN:  bus_rdata[0] = st_q.lim_en;
            REG_LIMIT:   bus_rdata    = st_q.limit;
            default: ;
        endcase
    end

    assign addend   = st_q.addend;
    assign limit    = st_q.limit;
    assign soft_rst = st_q.ctrl_rst;

    // R4: a low-word read captures the high word of that same cycle
    p_shadow_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == REG_TIME_LO))
        |=> (st_q.shadow_hi == $past(time_now[TIME_W-1:WORD_W])));

    // R6: the limit only moves while its enable was set
    p_limit_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.limit != $past(st_q.limit)) |-> $past(st_q.lim_en));
endmodule

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter
    import tod_pkg::*;
#(
    parameter int          WORD_W       = 32,
    parameter logic [31:0] ADDEND_RESET = 32'hA000_0000,
    parameter logic [31:0] LIMIT_RESET  = 32'hFFFF_FFFF,
    localparam int         TIME_W       = 2 * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [TIME_W-1:0]     time_now,
    output logic                  tick
);
    logic [WORD_W-1:0] addend;
    logic [WORD_W-1:0] limit;
    logic              soft_rst;
    logic              load;
    logic [TIME_W-1:0] load_val;
    logic              carry;

    tod_regs #(
        .WORD_W      (WORD_W),
        .ADDEND_RESET(ADDEND_RESET),
        .LIMIT_RESET (LIMIT_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .time_now (time_now),
        .addend   (addend),
        .limit    (limit),
        .soft_rst (soft_rst),
        .load     (load),
        .load_val (load_val)
    );

    tod_phase_acc #(.ACC_W(WORD_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (soft_rst | load),
        .addend(addend),
        .carry (carry)
    );

    tod_time_count #(.WORD_W(WORD_W)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (soft_rst),
        .load    (load),
        .load_val(load_val),
        .tick    (carry),
        .limit   (limit),
        .time_q  (time_now)
    );

    assign tick = carry;

    // R3: a load sets the time on the next clock
    p_load_applies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !soft_rst) |=> (time_now == $past(load_val)));
endmodule

// File: tb/test_ptp_tod_counter.sv
`timescale 1ns/1ps
module test_ptp_tod_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] time_now;
    logic        tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ptp_tod_counter i_ptp_tod_counter (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .time_now(time_now), .tick(tick)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // called at a negedge; consumes one clock edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] predict(input logic [31:0] lo0, input logic [31:0] hi0,
                                            input logic [31:0] lim, input logic [31:0] a,
                                            input longint unsigned m);
        longint unsigned t, tot, span, hi, lo;
        t   = (m * longint'(a)) >> 32;
        hi  = hi0; lo = lo0;
        span = longint'(lim) + 1;
        if (lo > lim && t > 0) begin
            hi = hi + 1; lo = 0; t = t - 1;
        end
        tot = lo + t;
        hi  = hi + tot / span;
        lo  = tot % span;
        return {hi[31:0], lo[31:0]};
    endfunction

    task automatic set_time(input logic [31:0] lo, input logic [31:0] hi);
        wr(3'd2, lo);
        wr(3'd3, hi);
    endtask

    task automatic read_time(output logic [63:0] t);
        logic [31:0] l, h;
        rd(3'd2, l);
        rd(3'd3, h);
        t = {h, l};
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [63:0] t;
        logic [31:0] adds [8];
        int          ms   [6];
        adds = '{32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 32'hA000_0000,
                 32'hFFFF_FFFF, 32'hA800_0000, 32'h9800_0000, 32'h1234_5679};
        ms   = '{1, 2, 5, 33, 200, 1000};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(3'd1, d); check("R1 addend", {32'h0, d}, 64'hA000_0000);
        rd(3'd0, d); check("R1 ctrl", {32'h0, d}, 64'h0);
        rd(3'd4, d); check("R1 limit enable", {32'h0, d}, 64'h0);
        rd(3'd5, d); check("R1 limit", {32'h0, d}, 64'hFFFF_FFFF);
        rd(3'd3, d); check("R1 shadow high", {32'h0, d}, 64'h0);

        // R2 / R8 sweep of addends and window lengths
        foreach (adds[i]) begin
            foreach (ms[j]) begin
                logic [31:0] l0, h0;
                l0 = 32'hFFFF_FF00 + 32'(i * 7 + j);
                h0 = 32'(i * 16 + j);
                wr(3'd1, adds[i]);
                set_time(l0, h0);
                idle(ms[j]);
                read_time(t);
                check((i >= 5) ? "R8 trimmed rate" : "R2 rate", t,
                      predict(l0, h0, 32'hFFFF_FFFF, adds[i], longint'(ms[j])));
            end
        end
        rd(3'd1, d); check("R8 addend readback", {32'h0, d}, 64'h1234_5679);

        // R4 coherent pair across a low-word wrap (R5 carry)
        wr(3'd1, 32'hFFFF_FFFF);
        set_time(32'hFFFF_FFF0, 32'd5);
        idle(16);
        read_time(t);
        check("R4 coherent pair at wrap", t, 64'h0000_0005_FFFF_FFFF);
        read_time(t);
        check("R5 full carry", t, predict(32'hFFFF_FFF0, 32'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 18));

        // R3 low write alone leaves time untouched
        wr(3'd1, 32'h8000_0000);
        set_time(32'd1000, 32'd9);
        wr(3'd2, 32'd77);
        idle(10);
        read_time(t);
        check("R3 staged low ignored", t, predict(32'd1000, 32'd9, 32'hFFFF_FFFF, 32'h8000_0000, 11));

        // R6 guarded limit
        wr(3'd5, 32'd100);
        rd(3'd5, d); check("R6 write without enable", {32'h0, d}, 64'hFFFF_FFFF);
        wr(3'd4, 32'd1);
        wr(3'd5, 32'd99);
        wr(3'd4, 32'd0);
        wr(3'd5, 32'd50);
        rd(3'd5, d); check("R6 guarded write", {32'h0, d}, 64'd99);

        // R5 programmable wrap, several windows
        for (int k = 1; k <= 60; k += 7) begin
            set_time(32'd90, 32'd2);
            idle(k);
            read_time(t);
            check("R5 short wrap", t, predict(32'd90, 32'd2, 32'd99, 32'h8000_0000, longint'(k)));
        end
        // R5 low word above the limit wraps on the next tick
        set_time(32'd200, 32'd4);
        idle(5);
        read_time(t);
        check("R5 above limit", t, predict(32'd200, 32'd4, 32'd99, 32'h8000_0000, 5));
        wr(3'd4, 32'd1);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd4, 32'd0);

        // R7 soft reset
        wr(3'd1, 32'hA000_0000);
        set_time(32'h1234, 32'h55);
        wr(3'd0, 32'd1);
        idle(20);
        read_time(t);
        check("R7 held at zero", t, 64'h0);
        set_time(32'h1, 32'h1);
        read_time(t);
        check("R7 load ignored", t, 64'h0);
        rd(3'd1, d); check("R7 addend kept", {32'h0, d}, 64'hA000_0000);
        wr(3'd0, 32'd0);
        idle(40);
        read_time(t);
        check("R7 restart from zero", t, predict(32'd0, 32'd0, 32'hFFFF_FFFF, 32'hA000_0000, 40));

        finish_run();
    end
endmodule